// File: doc/BRIEF.md
# Two-Step Successive-Approximation Sequencer

This block is the digital sequencer of a 14-bit fully differential successive-approximation converter. It gets there by using one 7-bit binary-weighted capacitor array twice. The first pass resolves the upper half of the code against a coarse reference pair. Between passes, a dummy capacitor on the negative half is switched and every negative-side plate is given a fine-reference offset. The second pass then resolves the lower half against the scaled fine pair, on the same capacitors and in the same order.

A frame is a fixed run of converter clocks. Sampling comes first, with the plates steered to the input nets and the top plates tied to common mode. Then come the bit decisions, one per clock, and the frame ends with one output clock. The block reads a single comparator decision. For each capacitor it drives a bottom-plate select code on each half, plus a fine-step select on each half and the dummy select. It publishes the assembled code with a data-ready flag.

Top module: `sar2_ctrl`

## Requirements
- R1: A start accepted on a clock edge begins a frame of SAMPLE_CLKS + 2*HALF_BITS + OUT_CLKS clocks (18 by default). The code becomes valid, and ready rises, on the 17th edge after the accepting edge.
- R2: During the three sampling clocks, cm_en is 1 and every plate select is input (code 2'b00). cm_en drops on the edge that starts the fourth clock, which is the hold clock.
- R3: Plate codes are 2'b01 for the low reference and 2'b10 for the high reference. On the edge that starts the hold clock, positive capacitor 6 goes high and the others go low. The negative half always carries the opposite code on each capacitor; input mirrors input.
- R4: A comparator value of 1 reverts the trial capacitor, and the stored bit is the inverse of the comparator value. Take a comparator that outputs 1 when 128*(coarse high weights) + (positive fine weights) exceeds the input value. Against that comparator, the result equals the input value.
- R5: After the 7th decision, dummy_fine rises and the negative fine selects step to 1. In every clock after that, fine_p XOR fine_n is all ones. When dummy_fine is 0, both fine vectors are zero.
- R6: Fine bit k (result bit k, k = 0..6) is tried on fine_p[k] and fine_n[k], which belong to the capacitor that resolved coarse bit k+7. The first fine clock shows fine_p = 7'h40 and fine_n = 7'h3F.
- R7: Decisions run MSB first. After the first decision, capacitor 6 is back at low if result bit 13 is 0, and capacitor 5 carries the next trial.
- R8: ready stays 1 from its rise until the edge that ends the first clock of the next frame, idle clocks included.
- R9: result changes only on the edge where ready rises. It holds through the whole of the following frame until that frame's output edge.
- R10: A start is accepted only when idle or during the output clock. A start during any earlier clock of a frame has no effect on frame timing or on the result.
- R11: After reset, ready, result, cm_en, dummy_fine, the fine selects and all plate selects are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame request, sampled on the rising edge |
| cmp | input | 1 | Comparator decision, 1 when the trial level is too high |
| cm_en | output | 1 | Top plates tied to common mode (sampling) |
| pos_sel | output | 14 | Positive-half plate codes, 2 bits per capacitor, capacitor i at [2i+1:2i] |
| neg_sel | output | 14 | Negative-half plate codes, same layout |
| fine_p | output | 7 | Positive-half fine-step selects, one per capacitor |
| fine_n | output | 7 | Negative-half fine-step selects, one per capacitor |
| dummy_fine | output | 1 | Negative-half dummy capacitor switched for the fine pass |
| ready | output | 1 | Result valid |
| result | output | 14 | Conversion code, MSB first |

## Verification
The bench builds the sequencer with its default parameters: a 7-capacitor array, three sampling clocks and one output clock. This puts every one of the 16384 codes within reach of a behavioural comparator built from the plate outputs alone. With only 18 clocks per frame, dozens of frames fit in a short run. The bench mixes random input levels with the extremes 0 and 16383 and with the values on either side of the coarse/fine boundary. It also runs back-to-back frames, an idle gap, and stray start pulses in the middle and at the end of the decision clocks.

// File: rtl/sar2_pkg.sv
package sar2_pkg;

    localparam int HALF_BITS_DEF   = 7;
    localparam int SAMPLE_CLKS_DEF = 3;
    localparam int OUT_CLKS_DEF    = 1;

    typedef enum logic [1:0] {
        PL_IN = 2'b00,
        PL_LO = 2'b01,
        PL_HI = 2'b10
    } plate_e;

    // sequence strobes decoded from the frame counter, one per clock
    typedef struct packed {
        logic go;      // start accepted this edge
        logic hold;    // last sampling clock: next edge enters hold
        logic coarse;  // a coarse decision is latched this edge
        logic fine;    // a fine decision is latched this edge
        logic last;    // final decision of the frame
        logic first;   // first clock of a frame
    } seq_t;

    function automatic plate_e opposite(input plate_e p);
        case (p)
            PL_LO:   return PL_HI;
            PL_HI:   return PL_LO;
            default: return PL_IN;
        endcase
    endfunction

    function automatic int frame_clks(input int half, input int samp, input int outc);
        return samp + 2 * half + outc;
    endfunction

endpackage

// File: rtl/sar2_timer.sv
module sar2_timer
    import sar2_pkg::*;
#(
    parameter int HALF_BITS   = HALF_BITS_DEF,
    parameter int SAMPLE_CLKS = SAMPLE_CLKS_DEF,
    parameter int OUT_CLKS    = OUT_CLKS_DEF,
    localparam int FRAME = frame_clks(HALF_BITS, SAMPLE_CLKS, OUT_CLKS),
    localparam int CW    = $clog2(FRAME),
    localparam int IW    = (HALF_BITS > 1) ? $clog2(HALF_BITS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output seq_t          seq,
    output logic [IW-1:0] idx,
    output logic          run,
    output logic [CW-1:0] cnt
);
    localparam int LAST      = FRAME - 1;
    localparam int DEC_FIRST = SAMPLE_CLKS;
    localparam int FINE_BASE = SAMPLE_CLKS + HALF_BITS;
    localparam int DEC_LAST  = SAMPLE_CLKS + 2 * HALF_BITS - 1;

    logic go;
    int   pos;

    assign go = start && (!run || (int'(cnt) == LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (go) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (run) begin
            if (int'(cnt) == LAST) begin
                run <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        pos        = int'(cnt);
        seq.go     = go;
        seq.hold   = run && (pos == DEC_FIRST - 1);
        seq.coarse = run && (pos >= DEC_FIRST) && (pos < FINE_BASE);
        seq.fine   = run && (pos >= FINE_BASE) && (pos <= DEC_LAST);
        seq.last   = run && (pos == DEC_LAST);
        seq.first  = run && (pos == 0);
        if (pos >= FINE_BASE) begin
            idx = IW'(HALF_BITS - 1 - (pos - FINE_BASE));
        end else begin
            idx = IW'(HALF_BITS - 1 - (pos - DEC_FIRST));
        end
    end

endmodule

// File: rtl/sar2_plates.sv
module sar2_plates
    import sar2_pkg::*;
#(
    parameter int HALF_BITS = HALF_BITS_DEF,
    localparam int IW = (HALF_BITS > 1) ? $clog2(HALF_BITS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  seq_t                   seq,
    input  logic [IW-1:0]          idx,
    input  logic                   cmp,
    output logic [2*HALF_BITS-1:0] pos_sel,
    output logic [2*HALF_BITS-1:0] neg_sel,
    output logic [HALF_BITS-1:0]   fine_p,
    output logic [HALF_BITS-1:0]   fine_n,
    output logic                   dummy_fine,
    output logic                   cm_en
);
    localparam int TOP = HALF_BITS - 1;

    plate_e pos_q [HALF_BITS];
    plate_e neg_q [HALF_BITS];
    logic [HALF_BITS-1:0] fp_q, fn_q;
    logic dummy_q, cm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HALF_BITS; i++) begin
                pos_q[i] <= PL_IN;
                neg_q[i] <= PL_IN;
            end
            fp_q    <= '0;
            fn_q    <= '0;
            dummy_q <= 1'b0;
            cm_q    <= 1'b0;
        end else if (seq.go) begin
            for (int i = 0; i < HALF_BITS; i++) begin
                pos_q[i] <= PL_IN;
                neg_q[i] <= PL_IN;
            end
            fp_q    <= '0;
            fn_q    <= '0;
            dummy_q <= 1'b0;
            cm_q    <= 1'b1;
        end else if (seq.hold) begin
            // hold: top plates float, first coarse trial on the largest capacitor
            cm_q <= 1'b0;
            for (int i = 0; i < HALF_BITS; i++) begin
                pos_q[i] <= (i == TOP) ? PL_HI : PL_LO;
                neg_q[i] <= (i == TOP) ? PL_LO : PL_HI;
            end
        end else if (seq.coarse) begin
            if (cmp) begin
                pos_q[idx] <= PL_LO;
                neg_q[idx] <= PL_HI;
            end
            if (idx != '0) begin
                pos_q[idx - 1'b1] <= PL_HI;
                neg_q[idx - 1'b1] <= PL_LO;
            end else begin
                // pass change: dummy switched, negative plates step by the fine
                // amount, and the first fine trial goes on the largest capacitor
                dummy_q   <= 1'b1;
                fn_q      <= {1'b0, {(HALF_BITS - 1){1'b1}}};
                fp_q      <= '0;
                fp_q[TOP] <= 1'b1;
            end
        end else if (seq.fine) begin
            if (cmp) begin
                fp_q[idx] <= 1'b0;
                fn_q[idx] <= 1'b1;
            end
            if (idx != '0) begin
                fp_q[idx - 1'b1] <= 1'b1;
                fn_q[idx - 1'b1] <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < HALF_BITS; g++) begin : g_pack
        assign pos_sel[2*g +: 2] = pos_q[g];
        assign neg_sel[2*g +: 2] = neg_q[g];
    end

    assign fine_p     = fp_q;
    assign fine_n     = fn_q;
    assign dummy_fine = dummy_q;
    assign cm_en      = cm_q;

endmodule

// File: rtl/sar2_result.sv
module sar2_result
    import sar2_pkg::*;
#(
    parameter int HALF_BITS = HALF_BITS_DEF,
    localparam int RW = 2 * HALF_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_t          seq,
    input  logic          cmp,
    output logic          ready,
    output logic [RW-1:0] result
);
    logic [RW-1:0] dec_sr;
    logic          bit_now;

    assign bit_now = ~cmp;

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_sr <= '0;
            result <= '0;
            ready  <= 1'b0;
        end else begin
            if (seq.coarse || seq.fine) begin
                dec_sr <= {dec_sr[RW-2:0], bit_now};
            end
            if (seq.last) begin
                result <= {dec_sr[RW-2:0], bit_now};
                ready  <= 1'b1;
            end else if (seq.first) begin
                ready  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sar2_ctrl.sv
module sar2_ctrl
    import sar2_pkg::*;
#(
    parameter int HALF_BITS   = HALF_BITS_DEF,
    parameter int SAMPLE_CLKS = SAMPLE_CLKS_DEF,
    parameter int OUT_CLKS    = OUT_CLKS_DEF,
    localparam int RW = 2 * HALF_BITS,
    localparam int CW = $clog2(frame_clks(HALF_BITS, SAMPLE_CLKS, OUT_CLKS)),
    localparam int IW = (HALF_BITS > 1) ? $clog2(HALF_BITS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   cmp,
    output logic                   cm_en,
    output logic [2*HALF_BITS-1:0] pos_sel,
    output logic [2*HALF_BITS-1:0] neg_sel,
    output logic [HALF_BITS-1:0]   fine_p,
    output logic [HALF_BITS-1:0]   fine_n,
    output logic                   dummy_fine,
    output logic                   ready,
    output logic [RW-1:0]          result
);
    seq_t          seq;
    logic [IW-1:0] idx;
    logic          run;
    logic [CW-1:0] cnt;

    sar2_timer #(
        .HALF_BITS  (HALF_BITS),
        .SAMPLE_CLKS(SAMPLE_CLKS),
        .OUT_CLKS   (OUT_CLKS)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .seq  (seq),
        .idx  (idx),
        .run  (run),
        .cnt  (cnt)
    );

    sar2_plates #(
        .HALF_BITS(HALF_BITS)
    ) u_plates (
        .clk       (clk),
        .rst       (rst),
        .seq       (seq),
        .idx       (idx),
        .cmp       (cmp),
        .pos_sel   (pos_sel),
        .neg_sel   (neg_sel),
        .fine_p    (fine_p),
        .fine_n    (fine_n),
        .dummy_fine(dummy_fine),
        .cm_en     (cm_en)
    );

    sar2_result #(
        .HALF_BITS(HALF_BITS)
    ) u_result (
        .clk   (clk),
        .rst   (rst),
        .seq   (seq),
        .cmp   (cmp),
        .ready (ready),
        .result(result)
    );

endmodule

// File: rtl/sar2_ctrl_chk.sv
module sar2_ctrl_chk
    import sar2_pkg::*;
#(
    parameter int HALF_BITS   = HALF_BITS_DEF,
    parameter int SAMPLE_CLKS = SAMPLE_CLKS_DEF,
    parameter int OUT_CLKS    = OUT_CLKS_DEF,
    localparam int RW = 2 * HALF_BITS,
    localparam int FRAME = frame_clks(HALF_BITS, SAMPLE_CLKS, OUT_CLKS),
    localparam int CW = $clog2(FRAME)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   start,
    input logic                   cm_en,
    input logic [2*HALF_BITS-1:0] pos_sel,
    input logic [2*HALF_BITS-1:0] neg_sel,
    input logic [HALF_BITS-1:0]   fine_p,
    input logic [HALF_BITS-1:0]   fine_n,
    input logic                   dummy_fine,
    input logic                   ready,
    input logic [RW-1:0]          result,
    input logic                   run,
    input logic [CW-1:0]          cnt
);
    localparam int DEC_LAST = SAMPLE_CLKS + 2 * HALF_BITS - 1;

    for (genvar g = 0; g < HALF_BITS; g++) begin : g_mirror
        assert_half_mirror_R3: assert property (@(posedge clk) disable iff (rst)
            neg_sel[2*g +: 2] == opposite(plate_e'(pos_sel[2*g +: 2])));
    end

    assert_sample_inputs_R2: assert property (@(posedge clk) disable iff (rst)
        cm_en |-> (pos_sel == '0) && (neg_sel == '0));

    assert_cm_release_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cm_en) |-> run && (int'(cnt) == SAMPLE_CLKS));

    assert_fine_balance_R5: assert property (@(posedge clk) disable iff (rst)
        dummy_fine |-> &(fine_p ^ fine_n));

    assert_fine_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !dummy_fine |-> (fine_p == '0) && (fine_n == '0));

    assert_ready_rise_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> run && (int'(cnt) == DEC_LAST + 1));

    assert_ready_fall_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> run && (int'(cnt) == 1));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> $rose(ready));

    assert_mid_start_R10: assert property (@(posedge clk) disable iff (rst)
        (run && start && (int'(cnt) != FRAME - 1)) |=> run && (cnt == $past(cnt) + 1'b1));

endmodule

bind sar2_ctrl sar2_ctrl_chk #(
    .HALF_BITS  (HALF_BITS),
    .SAMPLE_CLKS(SAMPLE_CLKS),
    .OUT_CLKS   (OUT_CLKS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cm_en     (cm_en),
    .pos_sel   (pos_sel),
    .neg_sel   (neg_sel),
    .fine_p    (fine_p),
    .fine_n    (fine_n),
    .dummy_fine(dummy_fine),
    .ready     (ready),
    .result    (result),
    .run       (run),
    .cnt       (cnt)
);

// File: tb/sar2_ctrl_test.sv
module sar2_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cmp;
    logic        cm_en;
    logic [13:0] pos_sel, neg_sel;
    logic [6:0]  fine_p, fine_n;
    logic        dummy_fine, ready;
    logic [13:0] result;

    int total = 0;
    int bad   = 0;
    int target = 0;
    int dac;
    logic [13:0] exp_prev = '0;

    always #4 clk = ~clk;

    sar2_ctrl uut (
        .clk(clk), .rst(rst), .start(start), .cmp(cmp), .cm_en(cm_en),
        .pos_sel(pos_sel), .neg_sel(neg_sel), .fine_p(fine_p), .fine_n(fine_n),
        .dummy_fine(dummy_fine), .ready(ready), .result(result)
    );

    // behavioural comparator: positive-half weights against the input level
    always_comb begin
        dac = 0;
        for (int i = 0; i < 7; i++) begin
            dac = dac + ((((pos_sel[2*i +: 2] == 2'b10) ? 128 : 0) + int'(fine_p[i])) << i);
        end
        cmp = (dac > target);
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // runs one frame starting at the current negedge; returns in the output clock
    task automatic run_frame(input int x, input bit first_ever, input int stray_at);
        target = x;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 18; n++) begin
            if (n < 3) begin
                check(cm_en == 1'b1, "R2 cm_en in sampling", cm_en, 1);
                check(pos_sel == 14'h0 && neg_sel == 14'h0, "R2 plates at input", pos_sel, 0);
            end
            if (n == 3) begin
                check(cm_en == 1'b0, "R2 cm_en released", cm_en, 0);
                check(pos_sel == {2'b10, {6{2'b01}}}, "R3 first trial pos", pos_sel, {2'b10, {6{2'b01}}});
                check(neg_sel == {2'b01, {6{2'b10}}}, "R3 first trial neg", neg_sel, {2'b01, {6{2'b10}}});
            end
            if (n == 4) begin
                logic [13:0] e4;
                e4 = {(x >= 8192) ? 2'b10 : 2'b01, 2'b10, {5{2'b01}}};
                check(pos_sel == e4, "R7 msb first", pos_sel, e4);
            end
            if (n == 10) begin
                check(dummy_fine == 1'b1, "R5 dummy switched", dummy_fine, 1);
                check(fine_n == 7'h3F, "R5 negative fine step", fine_n, 7'h3F);
                check(fine_p == 7'h40, "R6 first fine trial", fine_p, 7'h40);
                check(pos_sel[13:12] == ((x >= 8192) ? 2'b10 : 2'b01), "R6 coarse kept", pos_sel[13:12], 0);
            end
            if (n == 0) check(ready == !first_ever, "R8 ready through first clock", ready, !first_ever);
            if (n >= 1 && n <= 16) check(ready == 1'b0, "R8 ready low", ready, 0);
            if (n <= 16) check(result == exp_prev, "R9 result holds", result, exp_prev);
            if (n == 17) begin
                check(ready == 1'b1, "R1 ready at output clock", ready, 1);
                check(int'(result) == x, "R4 conversion code", result, x);
                exp_prev = 14'(x);
            end
            if (n < 17) begin
                start = (n == stray_at);
                @(posedge clk);
                @(negedge clk);
                start = 1'b0;
            end
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int dir [8];
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ready == 1'b0 && result == 14'h0, "R11 reset ready/result", {ready, result}, 0);
        check(cm_en == 1'b0 && dummy_fine == 1'b0 && fine_p == 0 && fine_n == 0, "R11 reset selects",
              {cm_en, dummy_fine, fine_p, fine_n}, 0);
        check(pos_sel == 0 && neg_sel == 0, "R11 reset plates", pos_sel, 0);

        dir = '{0, 16383, 8192, 127, 128, 16256, 10837, 8191};
        run_frame(dir[0], 1'b1, -1);
        for (int i = 1; i < 8; i++) begin
            run_frame(dir[i], 1'b0, (i == 2) ? 5 : ((i == 5) ? 16 : -1)); // R10 stray starts
        end

        // idle gap: ready and result stay put, R8 and R9
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(ready == 1'b1, "R8 ready held while idle", ready, 1);
            check(result == exp_prev, "R9 result held while idle", result, exp_prev);
            if (k == 2) start = 1'b0;
        end

        for (int i = 0; i < 40; i++) begin
            int x;
            int stray;
            x = int'($urandom_range(0, 16383));
            stray = (i % 4 == 1) ? int'($urandom_range(0, 16)) : -1;  // R10 ignored mid-frame
            run_frame(x, 1'b0, stray);
            if (i % 7 == 3) begin
                repeat (2) @(posedge clk);
                @(negedge clk);
            end
        end
        finish_run();
    end

endmodule